// File: doc/BRIEF.md
# Checksummed Command Frame Builder

This block turns a command code and a short payload into a delimited byte frame and passes the bytes, one at a time, to a serial transmitter over a valid/ready byte stream. A host first writes the command code, the payload length and the payload bytes through a simple write port, then pulses `start`. The block sends the frame and then blocks until a companion receiver reports a verdict, positive or negative, on the reply link.

A frame is laid out as: opening delimiter, command code, count byte, the payload bytes, a one-byte XOR check value, and a closing delimiter. The check value is the XOR of every byte between the two delimiters. It is folded in one byte per accepted handshake, so it is ready by the time it has to be sent. The delimiters are not part of the check value. If no verdict arrives in time, the block reports a timeout and goes back to idle. The line itself (9600 baud, 8 data bits, no parity) is handled by the downstream transmitter.

Top module: `cmd_frame_tx`

## Requirements
- R1: After a `start` pulse in idle, the stream carries, in order: the opening delimiter (parameter, default 0x7E), the command code, the count byte, payload bytes 0 to count-1, the check byte, and the closing delimiter (parameter, default 0x7F).
- R2: The check byte equals the XOR of the command code, the count byte and all payload bytes. Neither delimiter is included.
- R3: A count of zero is legal and gives a frame of exactly 5 bytes, with no payload bytes.
- R4: Write encoding: `wr_sel`=0 loads the code from `wr_data`, 1 loads the length, and 2 loads payload byte `wr_idx`. A length above MAX_LEN (default 32) is clamped to MAX_LEN. The count byte sent equals the stored length.
- R5: A byte is consumed only when `tx_valid` and `tx_ready` are both high at a clock edge. While `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R6: After the closing delimiter is consumed, `tx_valid` is low and `busy` is high until the outcome. A verdict with `verdict_ack`=1 gives a one-cycle `done` pulse in the cycle after it is sampled; with `verdict_ack`=0 it gives a one-cycle `failed` pulse. In both cases `busy` is low in the same cycle as the pulse, and at most one of `done`, `failed`, `timeout` is high at a time.
- R7: The wait after the closing delimiter lasts TIMEOUT_CYC cycles. A verdict in its last cycle is still accepted. If none arrives, a one-cycle `timeout` pulse appears TIMEOUT_CYC cycles after the closing delimiter is consumed, together with a return to idle.
- R8: `start` has no effect while a frame is being sent or a verdict is awaited. No extra bytes appear, and the block is idle right after the outcome.
- R9: Writes are ignored while `busy` is high. A later frame sent without reloading carries the previously loaded code, length and payload.
- R10: A verdict while idle is ignored: no `done` or `failed` pulse and no change of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write target: 0 code, 1 length, 2 payload byte |
| wr_idx | input | ADDR_W | Payload byte index for wr_sel=2 |
| wr_data | input | 8 | Write data |
| start | input | 1 | Start request pulse |
| tx_data | output | 8 | Frame byte offered to the transmitter |
| tx_valid | output | 1 | tx_data holds a byte to send |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| verdict_valid | input | 1 | Reply verdict present |
| verdict_ack | input | 1 | 1 positive, 0 negative verdict |
| busy | output | 1 | Frame in flight or verdict awaited |
| done | output | 1 | One-cycle pulse: positive verdict |
| failed | output | 1 | One-cycle pulse: negative verdict |
| timeout | output | 1 | One-cycle pulse: no verdict in time |

## Verification
The hardest cases to reach are the edges of the reply window. A verdict in the very last waiting cycle must still count, and one cycle more must give a timeout. The bench counts negative clock edges from the consumption of the closing delimiter and places the verdict at exactly the TIMEOUT_CYC-th cycle. In a separate frame it withholds the verdict and checks that the timeout pulse appears exactly one cycle later than that point. Stalls from random `tx_ready`, and stray `start` and write requests during busy frames, exercise the hold and ignore rules. The following frame is then sent without reloading, to show that the stored contents did not change.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_CODE,
        ST_COUNT,
        ST_DATA,
        ST_CSUM,
        ST_EOF,
        ST_WAIT
    } cfb_state_e;

    localparam logic [1:0] SEL_CODE = 2'd0;
    localparam logic [1:0] SEL_LEN  = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;

endpackage

// File: rtl/cfb_payload_store.sv
module cfb_payload_store #(
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);

    logic [7:0] mem_q [MAX_LEN];
    logic [7:0] mem_d [MAX_LEN];

    always_comb begin
        for (int i = 0; i < int'(MAX_LEN); i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && (32'(wr_addr) < MAX_LEN)) begin
            mem_d[wr_addr] = wr_byte;
        end
    end

    for (genvar g = 0; g < int'(MAX_LEN); g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[g] <= 8'h00;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        if (32'(rd_addr) < MAX_LEN) begin
            rd_byte = mem_q[rd_addr];
        end
    end

endmodule

// File: rtl/cfb_xor_accum.sv
module cfb_xor_accum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       fold,
    input  logic [7:0] byte_in,
    output logic [7:0] sum
);

    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clear) begin
            sum_d = 8'h00;
        end else if (fold) begin
            sum_d = sum_q ^ byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= 8'h00;
        end else begin
            sum_q <= sum_d;
        end
    end

    assign sum = sum_q;

endmodule

// File: rtl/cfb_reply_timer.sv
module cfb_reply_timer #(
    parameter int unsigned TIMEOUT_CYC = 100,
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = '0;
        if (run && (count_q != CNT_W'(TIMEOUT_CYC - 1))) begin
            count_d = count_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign expire = run && (count_q == CNT_W'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
    import cfb_pkg::*;
#(
    parameter int unsigned MAX_LEN     = 32,
    parameter int unsigned TIMEOUT_CYC = 100,
    parameter logic [7:0]  SOF_BYTE    = 8'h7E,
    parameter logic [7:0]  EOF_BYTE    = 8'h7F,
    localparam int unsigned ADDR_W = $clog2(MAX_LEN),
    localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              start,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              verdict_valid,
    input  logic              verdict_ack,
    output logic              busy,
    output logic              done,
    output logic              failed,
    output logic              timeout
);

    typedef struct packed {
        cfb_state_e       state;
        logic [LEN_W-1:0] idx;
        logic [7:0]       code;
        logic [LEN_W-1:0] len;
        logic             done;
        logic             failed;
        logic             timeout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic       hs;
    logic       idle;
    logic       pay_wr;
    logic [7:0] pay_byte;
    logic [7:0] csum;
    logic       csum_clear;
    logic       csum_fold;
    logic       wait_run;
    logic       wait_expire;

    assign idle     = (ctl_q.state == ST_IDLE);
    assign hs       = tx_valid && tx_ready;
    assign pay_wr   = wr_en && idle && (wr_sel == SEL_DATA);
    assign wait_run = (ctl_q.state == ST_WAIT);

    cfb_payload_store #(
        .MAX_LEN (MAX_LEN),
        .ADDR_W  (ADDR_W)
    ) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pay_wr),
        .wr_addr (wr_idx),
        .wr_byte (wr_data),
        .rd_addr (ctl_q.idx[ADDR_W-1:0]),
        .rd_byte (pay_byte)
    );

    cfb_xor_accum i_csum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (csum_clear),
        .fold    (csum_fold),
        .byte_in (tx_data),
        .sum     (csum)
    );

    cfb_reply_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wait_run),
        .expire (wait_expire)
    );

    // Byte offered in each sending state
    always_comb begin
        tx_valid = 1'b1;
        tx_data  = 8'h00;
        unique case (ctl_q.state)
            ST_SOF:   tx_data = SOF_BYTE;
            ST_CODE:  tx_data = ctl_q.code;
            ST_COUNT: tx_data = 8'(ctl_q.len);
            ST_DATA:  tx_data = pay_byte;
            ST_CSUM:  tx_data = csum;
            ST_EOF:   tx_data = EOF_BYTE;
            default:  tx_valid = 1'b0;
        endcase
    end

    assign csum_clear = (ctl_q.state == ST_SOF);
    assign csum_fold  = hs && ((ctl_q.state == ST_CODE) ||
                               (ctl_q.state == ST_COUNT) ||
                               (ctl_q.state == ST_DATA));

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.done    = 1'b0;
        ctl_d.failed  = 1'b0;
        ctl_d.timeout = 1'b0;

        if (wr_en && idle) begin
            if (wr_sel == SEL_CODE) begin
                ctl_d.code = wr_data;
            end else if (wr_sel == SEL_LEN) begin
                if (32'(wr_data) > MAX_LEN) begin
                    ctl_d.len = LEN_W'(MAX_LEN);
                end else begin
                    ctl_d.len = LEN_W'(wr_data);
                end
            end
        end

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_SOF;
                    ctl_d.idx   = '0;
                end
            end
            ST_SOF: begin
                if (hs) ctl_d.state = ST_CODE;
            end
            ST_CODE: begin
                if (hs) ctl_d.state = ST_COUNT;
            end
            ST_COUNT: begin
                if (hs) begin
                    ctl_d.idx   = '0;
                    ctl_d.state = (ctl_q.len == '0) ? ST_CSUM : ST_DATA;
                end
            end
            ST_DATA: begin
                if (hs) begin
                    ctl_d.idx = ctl_q.idx + LEN_W'(1);
                    if (ctl_q.idx == ctl_q.len - LEN_W'(1)) begin
                        ctl_d.state = ST_CSUM;
                    end
                end
            end
            ST_CSUM: begin
                if (hs) ctl_d.state = ST_EOF;
            end
            ST_EOF: begin
                if (hs) ctl_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (verdict_valid) begin
                    ctl_d.done   = verdict_ack;
                    ctl_d.failed = !verdict_ack;
                    ctl_d.state  = ST_IDLE;
                end else if (wait_expire) begin
                    ctl_d.timeout = 1'b1;
                    ctl_d.state   = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, idx: '0, code: 8'h00, len: '0,
                       done: 1'b0, failed: 1'b0, timeout: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = !idle;
    assign done    = ctl_q.done;
    assign failed  = ctl_q.failed;
    assign timeout = ctl_q.timeout;

endmodule

// File: rtl/cfb_checker.sv
module cfb_checker #(
    parameter logic [7:0] SOF_BYTE = 8'h7E
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] tx_data,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       verdict_valid,
    input logic       verdict_ack,
    input logic       busy,
    input logic       done,
    input logic       failed,
    input logic       timeout
);

    a_r1_sof_leads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_data == SOF_BYTE));

    a_r5_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r6_wait_after_send: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_valid) |-> busy);

    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, failed, timeout}));

    a_r6_done_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_valid && verdict_valid && verdict_ack) |=> (done && !busy));

    a_r6_failed_from_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_valid && verdict_valid && !verdict_ack) |=> (failed && !busy));

    a_r7_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!busy && $past(busy && !tx_valid && !verdict_valid)));

    a_r10_idle_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && verdict_valid) |=> (!done && !failed));

endmodule

bind cmd_frame_tx cfb_checker #(
    .SOF_BYTE (SOF_BYTE)
) i_cfb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_data       (tx_data),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .verdict_valid (verdict_valid),
    .verdict_ack   (verdict_ack),
    .busy          (busy),
    .done          (done),
    .failed        (failed),
    .timeout       (timeout)
);

// File: tb/test_cmd_frame_tx.sv
module test_cmd_frame_tx;

    localparam int MAXL = 32;
    localparam int TMO  = 100;
    localparam logic [7:0] SOFV = 8'h7E;
    localparam logic [7:0] EOFV = 8'h7F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [4:0] wr_idx = 5'd0;
    logic [7:0] wr_data = 8'h00;
    logic       start = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       verdict_valid = 1'b0;
    logic       verdict_ack = 1'b0;
    logic       busy, done, failed, timeout;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] m_code;
    int         m_len;
    logic [7:0] m_pay [MAXL];

    always #10 clk = ~clk;

    cmd_frame_tx #(
        .MAX_LEN (MAXL), .TIMEOUT_CYC (TMO), .SOF_BYTE (SOFV), .EOF_BYTE (EOFV)
    ) i_cmd_frame_tx (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_idx (wr_idx), .wr_data (wr_data), .start (start),
        .tx_data (tx_data), .tx_valid (tx_valid), .tx_ready (tx_ready),
        .verdict_valid (verdict_valid), .verdict_ack (verdict_ack),
        .busy (busy), .done (done), .failed (failed), .timeout (timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_csum();
        logic [7:0] s = m_code ^ 8'(m_len);
        for (int i = 0; i < m_len; i++) s ^= m_pay[i];
        return s;
    endfunction

    task automatic wr(input logic [1:0] sel, input int idx, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 5'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [7:0] code, input int len);
        wr(2'd0, 0, code);
        m_code = code;
        wr(2'd1, 0, 8'(len));
        m_len = (len > MAXL) ? MAXL : len;
        for (int i = 0; i < m_len; i++) begin
            m_pay[i] = 8'($urandom);
            wr(2'd2, i, m_pay[i]);
        end
    endtask

    // mode: 0 nack, 1 ack, 2 timeout, 3 ack in last waiting cycle
    task automatic run_frame(input int mode, input bit noise);
        logic [7:0] expb [MAXL+5];
        logic [7:0] got  [MAXL+5];
        int n = 0;
        int guard = 0;
        int total = m_len + 5;
        bit pv = 0, pr = 0;
        logic [7:0] pd = 8'h00;
        bit early = 0;
        expb[0] = SOFV; expb[1] = m_code; expb[2] = 8'(m_len);
        for (int i = 0; i < m_len; i++) expb[3+i] = m_pay[i];
        expb[total-2] = exp_csum();
        expb[total-1] = EOFV;

        @(negedge clk);
        start = 1'b1;
        while (n < total && guard < 4000) begin
            @(negedge clk);
            guard++;
            start    = noise ? 1'($urandom) : 1'b0;
            wr_en    = noise ? 1'($urandom) : 1'b0;
            wr_sel   = 2'($urandom % 3);
            wr_idx   = 5'($urandom);
            wr_data  = 8'($urandom);
            tx_ready = ($urandom % 4) != 0;
            #1;
            if (pv && !pr)
                chk(tx_valid && tx_data == pd, "R5 hold while stalled", int'(tx_data), int'(pd));
            if (tx_valid && tx_ready) begin
                got[n] = tx_data;
                n++;
            end
            pv = tx_valid; pr = tx_ready; pd = tx_data;
        end
        chk(n == total, "R3 frame length", n, total);
        for (int i = 0; i < total; i++) begin
            if (i == 2)
                chk(got[i] == expb[i], "R4 count byte", int'(got[i]), int'(expb[i]));
            else if (i == total - 2)
                chk(got[i] == expb[i], "R2 check byte", int'(got[i]), int'(expb[i]));
            else
                chk(got[i] == expb[i], "R1 frame byte", int'(got[i]), int'(expb[i]));
        end

        @(negedge clk);
        tx_ready = 1'b0; wr_en = 1'b0;
        start = noise;
        chk(!tx_valid && busy, "R6 waiting after closing byte", int'({tx_valid, busy}), 1);
        if (mode < 2) begin
            verdict_valid = 1'b1; verdict_ack = mode[0];
            @(negedge clk);
            verdict_valid = 1'b0; start = 1'b0;
            chk(done == mode[0] && failed == !mode[0] && !busy && !timeout,
                "R6 verdict outcome", int'({done, failed, busy}), mode[0] ? 4 : 2);
        end else begin
            start = 1'b0;
            for (int c = 2; c <= TMO; c++) begin
                @(negedge clk);
                if (timeout) early = 1;
                if (mode == 3 && c == TMO) begin
                    verdict_valid = 1'b1; verdict_ack = 1'b1;
                end
            end
            @(negedge clk);
            verdict_valid = 1'b0;
            chk(!early, "R7 no early timeout", int'(early), 0);
            if (mode == 3)
                chk(done && !timeout && !busy, "R7 verdict in last cycle",
                    int'({done, timeout, busy}), 4);
            else
                chk(timeout && !done && !failed && !busy, "R7 timeout pulse",
                    int'({timeout, busy}), 2);
        end
        @(negedge clk);
        chk(!done && !failed && !timeout && !tx_valid && !busy,
            "R8 single pulse and idle after outcome",
            int'({done, failed, timeout, tx_valid, busy}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!tx_valid && !busy && !done && !failed && !timeout, "R1 reset idle",
            int'({tx_valid, busy, done, failed, timeout}), 0);
        rst_n = 1'b1;

        // R10: verdict while idle is ignored
        @(negedge clk);
        verdict_valid = 1'b1; verdict_ack = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!done && !failed && !busy, "R10 idle verdict ignored",
                int'({done, failed, busy}), 0);
        end
        verdict_valid = 1'b0;

        // R3: empty payload
        load(8'hA5, 0);
        run_frame(1, 1'b0);

        // R4: length clamp
        load(8'h3C, 40);
        run_frame(0, 1'b0);

        // R8, R9: noise while busy, then resend unchanged contents
        load(8'h11, 7);
        run_frame(1, 1'b1);
        run_frame(0, 1'b0);

        // R7: timeout and last-cycle verdict
        load(8'h5A, 3);
        run_frame(2, 1'b0);
        run_frame(3, 1'b0);

        // random frames
        for (int f = 0; f < 20; f++) begin
            load(8'($urandom), int'($urandom % (MAXL + 1)));
            run_frame(int'($urandom % 2), 1'($urandom));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule